// File: doc/BRIEF.md
# Four-Tap Staggered I2S Stream Generator

This block takes one stereo I2S stream with a fixed 64 bit clocks per frame and produces four I2S streams. Each stream is the input delayed by a different multiple of a quarter frame: 16, 32, 48 and 64 bit clocks. When four stereo converters are driven from these streams and their analog outputs are summed, the result is a simple four-times interpolation by staggered copies. The data lines of the two later streams are inverted so that those converters can form the opposite half of a balanced pair. Their word select lines keep normal polarity. The block runs entirely on the bit clock, nominally 2.8224 MHz, which is 64 times a 44.1 kHz frame rate.

A free-running counter on the bit clock produces a local word select with a 50% duty cycle. An upstream receiver can run as a clock slave to it. A mode input chooses whether the delay chain takes this local word select or an external one. The same counter also produces a complementary pair of dynamic-element-matching clocks at the bit clock divided by a power of two. Converters that do not need these clocks can leave them unconnected.

Word select and data are captured on the rising bit-clock edge into two shift chains. All delayed outputs and the matching clocks are re-timed on the falling edge, so that a converter sampling on the rising edge sees stable levels. A two-state sequencer blanks the delayed outputs after reset. In state FILL, which is entered on every reset, all delayed outputs are held low. On the 64th rising edge after reset the sequencer moves from FILL to LIVE. It stays in LIVE until the next reset, and no other transition exists.

Top module: `i2s_tap_interp`

## Requirements
- R1: Reset is synchronous and active high. From reset until the falling edge that follows the 64th rising edge after reset release, ws_out, sd_out, dem_clk and dem_clk_n are all 0. After the 64th rising edge they are driven.
- R2: Once live, ws_out[k] (k = 0..3) presents the word select sampled at rising edge n during the low phase that precedes rising edge n + 16*(k+1). The word select taps are never inverted.
- R3: Once live, sd_out[0] and sd_out[1] present the serial data delayed by 16 and 32 bit clocks with the same timing as R2, without inversion.
- R4: Once live, sd_out[2] and sd_out[3] present the logical inverse of the serial data delayed by 48 and 64 bit clocks.
- R5: All outputs change only on falling bit-clock edges. Across a rising edge they are stable.
- R6: After the falling edge that follows rising edge n (counted from reset release), ws_gen_out equals bit 5 of n mod 64. It is therefore low for 32 bit clocks after reset and then toggles every 32 bit clocks. This output is not blanked.
- R7: With ws_int_sel = 1 the chain samples ws_gen_out and ws_in has no effect on any output. With ws_int_sel = 0 the chain samples ws_in.
- R8: Once live, after the falling edge that follows rising edge n, dem_clk equals bit (DEM_DIV_LOG2-1) of n, giving a period of 2^DEM_DIV_LOG2 bit clocks. dem_clk_n is its exact complement.
- R9: A reset applied mid-stream clears both chains and the counter, and restarts the blanking period of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | Bit clock; chains sample on rising edge, outputs update on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ws_int_sel | input | 1 | 1: chain takes the locally generated word select; 0: takes ws_in |
| ws_in | input | 1 | External word select |
| sd_in | input | 1 | Serial audio data |
| ws_gen_out | output | 1 | Locally generated word select, 32 bit clocks high and 32 low |
| ws_out | output | NUM_TAPS | Delayed word select, bit k delayed 16*(k+1) bit clocks |
| sd_out | output | NUM_TAPS | Delayed data; bits at or above INV_FIRST inverted |
| dem_clk | output | 1 | Element-matching clock, bit clock divided by 2^DEM_DIV_LOG2 |
| dem_clk_n | output | 1 | Complement of dem_clk |

## Verification
The FILL to LIVE transition at rising edge 64 falls in the same cycle as the counter wrap. At that edge the local word select makes its falling transition and the matching clock changes phase. The first live output sample therefore carries a word select edge, a matching-clock edge and the end of blanking together. The bench runs in internal mode through this edge after both the initial and a mid-stream reset, and compares that first live sample against its own model. Mode changes are also made at random edges while data and word select toggle. The bench checks that each tap follows the source that was selected at the sampling edge 16*(k+1) clocks earlier.

// File: rtl/itp_pkg.sv
package itp_pkg;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_LIVE = 1'b1
    } warm_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/itp_frame_ctr.sv
module itp_frame_ctr #(
    parameter int CNT_W   = 6,
    parameter int WS_BIT  = 5,
    parameter int DEM_BIT = 2
) (
    input  logic clk,
    input  logic rst,
    output logic ws_gen,
    output logic dem_raw
);

    logic [CNT_W-1:0] cnt_q;
    logic             ws_q;

    // Rising-edge counter shared by the word select and matching clock.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Word select is re-timed to the falling edge like every stream output.
    always_ff @(negedge clk) begin
        if (rst) begin
            ws_q <= 1'b0;
        end else begin
            ws_q <= cnt_q[WS_BIT];
        end
    end

    assign ws_gen  = ws_q;
    assign dem_raw = cnt_q[DEM_BIT];

endmodule

// File: rtl/itp_tap_chain.sv
module itp_tap_chain #(
    parameter int NUM_TAPS = 4,
    parameter int TAP_STEP = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                din,
    output logic [NUM_TAPS-1:0] taps
);

    localparam int DEPTH = NUM_TAPS * TAP_STEP;

    logic [DEPTH-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[DEPTH-2:0], din};
        end
    end

    // Stage (k+1)*TAP_STEP-1 holds the sample from (k+1)*TAP_STEP-1 edges ago;
    // the falling-edge re-time adds the last bit clock of delay.
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign taps[k] = sr_q[(k+1)*TAP_STEP-1];
    end

endmodule

// File: rtl/itp_warmup_fsm.sv
module itp_warmup_fsm
    import itp_pkg::*;
#(
    parameter int FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst,
    output logic live
);

    localparam int          FILL_W    = $clog2(FRAME_BITS);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(FRAME_BITS - 1);

    warm_state_e       state_q, state_d;
    logic [FILL_W-1:0] fill_q, fill_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // Next state: FILL counts rising edges, leaves on the last stage.
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            ST_FILL: begin
                fill_d = fill_q + FILL_W'(1);
                if (fill_q == FILL_LAST) begin
                    state_d = ST_LIVE;
                end
            end
            ST_LIVE: begin
                fill_d = fill_q;
            end
            default: begin
                state_d = ST_FILL;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            ST_FILL: live = 1'b0;
            ST_LIVE: live = 1'b1;
            default: live = 1'b0;
        endcase
    end

endmodule

// File: rtl/itp_out_stage.sv
module itp_out_stage #(
    parameter int NUM_TAPS  = 4,
    parameter int INV_FIRST = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                live,
    input  logic [NUM_TAPS-1:0] ws_taps,
    input  logic [NUM_TAPS-1:0] sd_taps,
    input  logic                dem_raw,
    output logic [NUM_TAPS-1:0] ws_out,
    output logic [NUM_TAPS-1:0] sd_out,
    output logic                dem_clk,
    output logic                dem_clk_n
);

    logic [NUM_TAPS-1:0] inv_mask;

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_pol
        if (k >= INV_FIRST) begin : g_inv
            assign inv_mask[k] = 1'b1;
        end else begin : g_pass
            assign inv_mask[k] = 1'b0;
        end
    end

    always_ff @(negedge clk) begin
        if (rst || !live) begin
            ws_out    <= '0;
            sd_out    <= '0;
            dem_clk   <= 1'b0;
            dem_clk_n <= 1'b0;
        end else begin
            ws_out    <= ws_taps;
            sd_out    <= sd_taps ^ inv_mask;
            dem_clk   <= dem_raw;
            dem_clk_n <= ~dem_raw;
        end
    end

endmodule

// File: rtl/i2s_tap_interp.sv
module i2s_tap_interp
    import itp_pkg::*;
#(
    parameter int FRAME_BITS   = 64,
    parameter int NUM_TAPS     = 4,
    parameter int INV_FIRST    = 2,
    parameter int DEM_DIV_LOG2 = 3
) (
    input  logic                bck,
    input  logic                rst,
    input  logic                ws_int_sel,
    input  logic                ws_in,
    input  logic                sd_in,
    output logic                ws_gen_out,
    output logic [NUM_TAPS-1:0] ws_out,
    output logic [NUM_TAPS-1:0] sd_out,
    output logic                dem_clk,
    output logic                dem_clk_n
);

    localparam int TAP_STEP   = FRAME_BITS / NUM_TAPS;
    localparam int FRAME_LOG2 = $clog2(FRAME_BITS);
    localparam int CNT_W      = max_int(FRAME_LOG2, DEM_DIV_LOG2);

    logic                dem_raw;
    logic                ws_src;
    logic                live;
    logic [NUM_TAPS-1:0] ws_taps;
    logic [NUM_TAPS-1:0] sd_taps;

    itp_frame_ctr #(
        .CNT_W  (CNT_W),
        .WS_BIT (FRAME_LOG2 - 1),
        .DEM_BIT(DEM_DIV_LOG2 - 1)
    ) u_ctr (
        .clk    (bck),
        .rst    (rst),
        .ws_gen (ws_gen_out),
        .dem_raw(dem_raw)
    );

    assign ws_src = ws_int_sel ? ws_gen_out : ws_in;

    itp_tap_chain #(
        .NUM_TAPS(NUM_TAPS),
        .TAP_STEP(TAP_STEP)
    ) u_ws_chain (
        .clk (bck),
        .rst (rst),
        .din (ws_src),
        .taps(ws_taps)
    );

    itp_tap_chain #(
        .NUM_TAPS(NUM_TAPS),
        .TAP_STEP(TAP_STEP)
    ) u_sd_chain (
        .clk (bck),
        .rst (rst),
        .din (sd_in),
        .taps(sd_taps)
    );

    itp_warmup_fsm #(
        .FRAME_BITS(FRAME_BITS)
    ) u_fsm (
        .clk (bck),
        .rst (rst),
        .live(live)
    );

    itp_out_stage #(
        .NUM_TAPS (NUM_TAPS),
        .INV_FIRST(INV_FIRST)
    ) u_out (
        .clk      (bck),
        .rst      (rst),
        .live     (live),
        .ws_taps  (ws_taps),
        .sd_taps  (sd_taps),
        .dem_raw  (dem_raw),
        .ws_out   (ws_out),
        .sd_out   (sd_out),
        .dem_clk  (dem_clk),
        .dem_clk_n(dem_clk_n)
    );

endmodule

// File: rtl/itp_checker.sv
module itp_checker #(
    parameter int FRAME_BITS = 64,
    parameter int NUM_TAPS   = 4,
    parameter int INV_FIRST  = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_TAPS-1:0] ws_out,
    input logic [NUM_TAPS-1:0] sd_out,
    input logic                dem_clk,
    input logic                dem_clk_n,
    input logic                ws_gen_out
);

    localparam int TAP_STEP = FRAME_BITS / NUM_TAPS;
    localparam int LIMIT    = FRAME_BITS + TAP_STEP;
    localparam int AW       = $clog2(LIMIT + 1);
    localparam int RW       = $clog2(FRAME_BITS + 1);
    localparam int HALF     = FRAME_BITS / 2;

    logic [AW-1:0] age_q;
    logic [RW-1:0] run_q;
    logic          prev_ws_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != AW'(LIMIT)) begin
            age_q <= age_q + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ws_q <= 1'b0;
            seen_q    <= 1'b0;
            run_q     <= RW'(1);
        end else begin
            prev_ws_q <= ws_gen_out;
            if (ws_gen_out != prev_ws_q) begin
                run_q  <= RW'(1);
                seen_q <= 1'b1;
            end else if (run_q != RW'(FRAME_BITS)) begin
                run_q <= run_q + RW'(1);
            end
        end
    end

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (age_q < AW'(FRAME_BITS)) |-> (ws_out == '0 && sd_out == '0 && !dem_clk && !dem_clk_n))
        else $error("blanking violated"); // R1

    AST_DEM_PAIR: assert property (@(posedge clk) disable iff (rst)
        (age_q >= AW'(FRAME_BITS)) |-> (dem_clk != dem_clk_n))
        else $error("matching clocks not complementary"); // R8

    AST_WS_HALF_FRAME: assert property (@(posedge clk) disable iff (rst)
        (seen_q && (ws_gen_out != prev_ws_q)) |-> (run_q == RW'(HALF)))
        else $error("generated word select period wrong"); // R6

    for (genvar t = 0; t < NUM_TAPS - 1; t++) begin : g_stag
        localparam bit FLIP = ((t + 1) == INV_FIRST);
        logic [TAP_STEP-1:0] ws_hist_q;
        logic [TAP_STEP-1:0] sd_hist_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ws_hist_q <= '0;
                sd_hist_q <= '0;
            end else begin
                ws_hist_q <= {ws_hist_q[TAP_STEP-2:0], ws_out[t]};
                sd_hist_q <= {sd_hist_q[TAP_STEP-2:0], sd_out[t]};
            end
        end

        AST_WS_STAGGER: assert property (@(posedge clk) disable iff (rst)
            (age_q == AW'(LIMIT)) |-> (ws_out[t+1] == ws_hist_q[TAP_STEP-1]))
            else $error("word select tap spacing wrong"); // R2

        AST_SD_STAGGER: assert property (@(posedge clk) disable iff (rst)
            (age_q == AW'(LIMIT)) |-> (sd_out[t+1] == (sd_hist_q[TAP_STEP-1] ^ FLIP)))
            else $error("data tap spacing or polarity wrong"); // R4
    end

endmodule

bind i2s_tap_interp itp_checker #(
    .FRAME_BITS(FRAME_BITS),
    .NUM_TAPS  (NUM_TAPS),
    .INV_FIRST (INV_FIRST)
) u_itp_checker (
    .clk       (bck),
    .rst       (rst),
    .ws_out    (ws_out),
    .sd_out    (sd_out),
    .dem_clk   (dem_clk),
    .dem_clk_n (dem_clk_n),
    .ws_gen_out(ws_gen_out)
);

// File: tb/test_i2s_tap_interp.sv
module test_i2s_tap_interp;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME_BITS = 64;
    localparam int NUM_TAPS   = 4;
    localparam int INV_FIRST  = 2;
    localparam int DEM_LOG2   = 3;
    localparam int STEP       = FRAME_BITS / NUM_TAPS;
    localparam int FLOG2      = $clog2(FRAME_BITS);
    localparam int HIST       = 8192;

    logic                bck = 1'b0;
    logic                rst = 1'b1;
    logic                ws_int_sel = 1'b0;
    logic                ws_in = 1'b0;
    logic                sd_in = 1'b0;
    logic                ws_gen_out;
    logic [NUM_TAPS-1:0] ws_out;
    logic [NUM_TAPS-1:0] sd_out;
    logic                dem_clk;
    logic                dem_clk_n;

    int vectors = 0;
    int fails   = 0;
    int n       = 0;
    int cyc     = 0;
    bit done    = 0;
    bit src_ws [HIST];
    bit src_sd [HIST];

    i2s_tap_interp #(
        .FRAME_BITS  (FRAME_BITS),
        .NUM_TAPS    (NUM_TAPS),
        .INV_FIRST   (INV_FIRST),
        .DEM_DIV_LOG2(DEM_LOG2)
    ) i_i2s_tap_interp (
        .bck       (bck),
        .rst       (rst),
        .ws_int_sel(ws_int_sel),
        .ws_in     (ws_in),
        .sd_in     (sd_in),
        .ws_gen_out(ws_gen_out),
        .ws_out    (ws_out),
        .sd_out    (sd_out),
        .dem_clk   (dem_clk),
        .dem_clk_n (dem_clk_n)
    );

    always #(CLK_PERIOD/2) bck = ~bck;

    function automatic bit gen_ws(input int k);
        return bit'((k >> (FLOG2 - 1)) & 1);
    endfunction

    function automatic bit gen_dem(input int k);
        return bit'((k >> (DEM_LOG2 - 1)) & 1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", req, what, act, exp, n);
        end
    endtask

    // Outputs after the falling edge that follows rising edge n.
    task automatic check_outputs();
        chk(ws_gen_out == gen_ws(n), "R6", "ws_gen_out", int'(ws_gen_out), int'(gen_ws(n)));
        if (n < FRAME_BITS) begin
            // R1 / R9: blanking after reset
            chk(ws_out == '0, "R1", "ws_out blank", int'(ws_out), 0);
            chk(sd_out == '0, "R1", "sd_out blank", int'(sd_out), 0);
            chk({dem_clk, dem_clk_n} == 2'b00, "R1", "dem pair blank",
                int'({dem_clk, dem_clk_n}), 0);
        end else begin
            for (int k = 0; k < NUM_TAPS; k++) begin
                int  idx;
                bit  ews;
                bit  esd;
                idx = n - STEP * (k + 1) + 1;
                ews = src_ws[idx];
                esd = src_sd[idx] ^ (k >= INV_FIRST);
                chk(ws_out[k] == ews, "R2", $sformatf("ws_out[%0d]", k), int'(ws_out[k]), int'(ews));
                if (k >= INV_FIRST)
                    chk(sd_out[k] == esd, "R4", $sformatf("sd_out[%0d] inverted", k),
                        int'(sd_out[k]), int'(esd));
                else
                    chk(sd_out[k] == esd, "R3", $sformatf("sd_out[%0d]", k),
                        int'(sd_out[k]), int'(esd));
            end
            chk(dem_clk == gen_dem(n), "R8", "dem_clk", int'(dem_clk), int'(gen_dem(n)));
            chk(dem_clk_n == !gen_dem(n), "R8", "dem_clk_n", int'(dem_clk_n), int'(!gen_dem(n)));
        end
    endtask

    // Called just after a falling edge; drives inputs, then follows one bit clock.
    task automatic run_cycle(input bit mode, input bit wsi, input bit sdi);
        logic [2*NUM_TAPS+2:0] snap;
        ws_int_sel = mode;
        ws_in      = wsi;
        sd_in      = sdi;
        snap = {ws_out, sd_out, dem_clk, dem_clk_n, ws_gen_out};
        @(posedge bck);
        n++;
        cyc++;
        // R7: in internal mode the chain takes the generated word select
        src_ws[n] = mode ? gen_ws(n - 1) : wsi;
        src_sd[n] = sdi;
        #1;
        if (cyc % 7 == 0)
            chk(snap == {ws_out, sd_out, dem_clk, dem_clk_n, ws_gen_out}, "R5",
                "outputs moved at rising edge",
                int'({ws_out, sd_out, dem_clk, dem_clk_n, ws_gen_out}), int'(snap));
        @(negedge bck);
        #1;
        check_outputs();
    endtask

    task automatic apply_reset(input string tag);
        @(negedge bck);
        #1;
        rst = 1'b1;
        repeat (3) @(negedge bck);
        #1;
        chk(ws_out == '0 && sd_out == '0 && !dem_clk && !dem_clk_n && !ws_gen_out, tag,
            "outputs under reset", int'({ws_out, sd_out, dem_clk, dem_clk_n, ws_gen_out}), 0);
        rst = 1'b0;
        n   = 0;
    endtask

    initial begin
        void'($urandom(32'd7721));
        apply_reset("R1");

        // Internal word select, ws_in toggled randomly (R7: must not matter).
        repeat (200) run_cycle(1'b1, 1'($urandom % 2), 1'($urandom % 2));

        // External word select shaped like a real frame.
        for (int i = 0; i < 256; i++)
            run_cycle(1'b0, 1'((i >> 5) & 1), 1'($urandom % 2));

        // Random mode switching at random edges.
        begin
            bit m;
            m = 1'b0;
            for (int i = 0; i < 700; i++) begin
                if ($urandom % 23 == 0) m = ~m;
                run_cycle(m, 1'($urandom % 2), 1'($urandom % 2));
            end
        end

        // Directed: constant data, R4 polarity visible as steady levels.
        repeat (100) run_cycle(1'b0, 1'b1, 1'b1);
        repeat (100) run_cycle(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 100; i++) run_cycle(1'b0, 1'(i & 1), 1'(~i & 1));

        // R9: reset in mid-stream; warm-up edge meets counter wrap again.
        apply_reset("R9");
        repeat (180) run_cycle(1'b1, 1'($urandom % 2), 1'($urandom % 2));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule